// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a radix tree kept in memory. A walk starts from a process identifier, the base and size code of a process table, and the effective address. The walker first reads the 8-byte process-table entry for that identifier. That entry names the root directory, the index width of the root directory and the total number of translated address bits. The walker then reads one directory entry per level until it finds a leaf.

Each directory entry carries the base and index width of the level below it. The page size is not configured anywhere. It is simply the number of effective-address bits still untranslated when the leaf turns up.

The walker makes one 64-bit read at a time on a request/response port. When a walk ends it pulses `done` and reports one of three outcomes: a translation, a no-entry fault or a bad-configuration fault. For a translation it also returns the leaf entry, the leaf entry's memory address and the page size. It performs no permission check.

Top module: `rw_walker`

## Requirements
- R1: While and after reset, `busy`, `done` and `mem_req_valid` are all 0.
- R2: The process table holds 2^(`prt_size`+12) bytes in 16-byte slots. If `pid`*16 is greater than or equal to that size, the walk ends with fault code 2'b01 (no entry) and issues no memory read.
- R3: Otherwise the first read goes to `prt_base` + `pid`*16. In the returned word:
  - bits [55:8] give the root directory base, with the low 8 bits taken as zero;
  - bits [4:0] give the root index width;
  - bits [61:56] give the initial remaining size.
- R4: At each level the index is (ea >> (remaining - width)) masked to `width` bits. The entry is read at base + index*8.
- R5: If a level's index width is below 5, or exceeds the remaining size, the walk ends with fault code 2'b10 (bad configuration) and that level is not read.
- R6: A directory entry whose bit 63 (valid) is 0 ends the walk with fault code 2'b01.
- R7: A valid entry whose bit 62 (leaf) is 1 ends the walk with fault code 2'b00. After the level's index width is subtracted from the remaining size:
  - `page_shift` is the new remaining size;
  - `real_addr` is entry bits [55:12] (as an address with the low 12 bits zero) above `page_shift`, combined with the `ea` bits below `page_shift`;
  - `leaf_entry` is the full entry;
  - `leaf_addr` is the address the entry was read from.
- R8: A valid entry with bit 62 at 0 gives the next level's base from bits [55:8] (low 8 bits zero) and its index width from bits [4:0]. The remaining size is reduced by the current width.
- R9: At most 4 directory levels are read. A walk that would need a fifth directory read ends with fault code 2'b10.
- R10: The memory port and control handshake behave as follows:
  - a request holds its address steady until `mem_req_ready` accepts it;
  - only one read is outstanding at a time;
  - `done` is a one-cycle pulse after which `busy` falls;
  - `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ea | input | EA_W | Effective address to translate |
| pid | input | PID_W | Process identifier |
| prt_base | input | PA_W | Process table base address |
| prt_size | input | 5 | Process table size code (bytes = 2^(code+12)) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: walk finished, results valid |
| fault | output | 2 | 00 translated, 01 no entry, 10 bad configuration |
| real_addr | output | PA_W | Translated real address |
| leaf_entry | output | 64 | Leaf entry as read |
| leaf_addr | output | PA_W | Memory address of the leaf entry |
| page_shift | output | $clog2(EA_W) | Log2 of the page size |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | PA_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
If the remaining-size or base register is wrong, the very next read goes to a different address. The bench counts reads and computes each expected address, so it catches this. The same error also surfaces one level later as a changed `page_shift` or `real_addr` on the `done` cycle.

If the level counter or the width check is wrong, a walk ends a level early or late. That shows up within the same walk as a wrong fault code and a wrong read count. The sweep over hundreds of hashed addresses uses a mixed table of leaves, holes, bad widths and deep chains, while the memory stalls at random. Together these reach every state transition many times.

// File: rtl/rw_pkg.sv
package rw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRT_REQ,
    S_PRT_WAIT,
    S_DIR_REQ,
    S_DIR_WAIT,
    S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_NOENT  = 2'b01,
    FLT_BADCFG = 2'b10
  } walk_fault_e;

  localparam int ENTRY_W   = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int BASE_LO   = 8;
  localparam int RPN_LO    = 12;
  localparam int NLS_W     = 5;
  localparam int RTS_LO    = 56;
  localparam int SZ_W      = 5;
endpackage

// File: rtl/rw_prt_locate.sv
module rw_prt_locate #(
  parameter int PID_W    = 16,
  parameter int PA_W     = 56,
  parameter int ENTRY_LG = 4
) (
  input  logic [PID_W-1:0]        pid,
  input  logic [PA_W-1:0]         base,
  input  logic [rw_pkg::SZ_W-1:0] size_code,
  output logic                    in_range,
  output logic [PA_W-1:0]         entry_addr
);
  localparam int SHIFT_BASE = 12 - ENTRY_LG;

  logic [6:0]       sh;
  logic [PID_W-1:0] hi_bits;

  always_comb begin
    sh         = 7'(size_code) + 7'(SHIFT_BASE);
    hi_bits    = pid >> sh;
    in_range   = (hi_bits == '0);
    entry_addr = base + (PA_W'(pid) << ENTRY_LG);
  end
endmodule

// File: rtl/rw_index_gen.sv
module rw_index_gen #(
  parameter int EA_W     = 64,
  parameter int PA_W     = 56,
  parameter int MIN_BITS = 5,
  localparam int SH_W    = $clog2(EA_W)
) (
  input  logic [EA_W-1:0]          ea,
  input  logic [SH_W-1:0]          rem,
  input  logic [rw_pkg::NLS_W-1:0] nls,
  input  logic [PA_W-1:0]          base,
  output logic                     cfg_bad,
  output logic [PA_W-1:0]          entry_addr
);
  logic [SH_W-1:0] sh;
  logic [EA_W-1:0] msk;
  logic [EA_W-1:0] idx;

  always_comb begin
    cfg_bad    = (int'(nls) < MIN_BITS) || (SH_W'(nls) > rem);
    sh         = rem - SH_W'(nls);
    msk        = (EA_W'(1) << nls) - EA_W'(1);
    idx        = (ea >> sh) & msk;
    entry_addr = base + PA_W'(idx << 3);
  end
endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge #(
  parameter int PA_W  = 56,
  parameter int SH_W  = 6
) (
  input  logic [PA_W-1:0] rpn,
  input  logic [PA_W-1:0] ea_low,
  input  logic [SH_W-1:0] shift,
  output logic [PA_W-1:0] real_addr
);
  logic [PA_W-1:0] msk;

  always_comb begin
    msk       = (PA_W'(1) << shift) - PA_W'(1);
    real_addr = (rpn & ~msk) | (ea_low & msk);
  end
endmodule

// File: rtl/rw_walker.sv
module rw_walker
  import rw_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int PA_W       = 56,
  parameter int PID_W      = 16,
  parameter int MAX_LEVELS = 4,
  parameter int MIN_BITS   = 5,
  parameter int PRT_LG     = 4,
  localparam int SH_W      = $clog2(EA_W),
  localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [EA_W-1:0]     ea,
  input  logic [PID_W-1:0]    pid,
  input  logic [PA_W-1:0]     prt_base,
  input  logic [SZ_W-1:0]     prt_size,
  output logic                busy,
  output logic                done,
  output logic [1:0]          fault,
  output logic [PA_W-1:0]     real_addr,
  output logic [ENTRY_W-1:0]  leaf_entry,
  output logic [PA_W-1:0]     leaf_addr,
  output logic [SH_W-1:0]     page_shift,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data
);
  walk_state_e        state_q, state_d;
  logic [EA_W-1:0]    ea_q, ea_d;
  logic [PA_W-1:0]    base_q, base_d;
  logic [NLS_W-1:0]   nls_q, nls_d;
  logic [SH_W-1:0]    rem_q, rem_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic [PA_W-1:0]    prt_addr_q, prt_addr_d;
  walk_fault_e        fault_q, fault_d;
  logic [PA_W-1:0]    ra_q, ra_d;
  logic [ENTRY_W-1:0] leaf_q, leaf_d;
  logic [PA_W-1:0]    la_q, la_d;
  logic [SH_W-1:0]    ps_q, ps_d;
  logic               ctx_en, res_en;

  logic               pid_ok;
  logic [PA_W-1:0]    prt_entry_addr;
  logic               cfg_bad;
  logic [PA_W-1:0]    dir_addr;
  logic [PA_W-1:0]    merge_ra;
  logic [SH_W-1:0]    rem_after;
  logic               lvl_full;
  logic               dir_stop;

  logic               ent_valid, ent_leaf;
  logic [PA_W-1:0]    ent_base, ent_rpn;
  logic [NLS_W-1:0]   ent_nls;
  logic [SH_W-1:0]    ent_rts;

  rw_prt_locate #(.PID_W(PID_W), .PA_W(PA_W), .ENTRY_LG(PRT_LG)) u_prt (
    .pid(pid), .base(prt_base), .size_code(prt_size),
    .in_range(pid_ok), .entry_addr(prt_entry_addr)
  );

  rw_index_gen #(.EA_W(EA_W), .PA_W(PA_W), .MIN_BITS(MIN_BITS)) u_idx (
    .ea(ea_q), .rem(rem_q), .nls(nls_q), .base(base_q),
    .cfg_bad(cfg_bad), .entry_addr(dir_addr)
  );

  rw_leaf_merge #(.PA_W(PA_W), .SH_W(SH_W)) u_merge (
    .rpn(ent_rpn), .ea_low(ea_q[PA_W-1:0]), .shift(rem_after),
    .real_addr(merge_ra)
  );

  // Entry field decode
  always_comb begin
    ent_valid = mem_rsp_data[VALID_BIT];
    ent_leaf  = mem_rsp_data[LEAF_BIT];
    ent_base  = {mem_rsp_data[PA_W-1:BASE_LO], {BASE_LO{1'b0}}};
    ent_rpn   = {mem_rsp_data[PA_W-1:RPN_LO], {RPN_LO{1'b0}}};
    ent_nls   = mem_rsp_data[NLS_W-1:0];
    ent_rts   = mem_rsp_data[RTS_LO+SH_W-1:RTS_LO];
    rem_after = rem_q - SH_W'(nls_q);
    lvl_full  = (lvl_q == LVL_W'(MAX_LEVELS));
    dir_stop  = cfg_bad || lvl_full;
  end

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    ea_d       = ea_q;
    base_d     = base_q;
    nls_d      = nls_q;
    rem_d      = rem_q;
    lvl_d      = lvl_q;
    prt_addr_d = prt_addr_q;
    fault_d    = fault_q;
    ra_d       = ra_q;
    leaf_d     = leaf_q;
    la_d       = la_q;
    ps_d       = ps_q;
    ctx_en     = 1'b0;
    res_en     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          ctx_en     = 1'b1;
          res_en     = 1'b1;
          ea_d       = ea;
          prt_addr_d = prt_entry_addr;
          lvl_d      = '0;
          if (pid_ok) begin
            fault_d = FLT_NONE;
            state_d = S_PRT_REQ;
          end else begin
            fault_d = FLT_NOENT;
            state_d = S_DONE;
          end
        end
      end
      S_PRT_REQ: begin
        if (mem_req_ready) state_d = S_PRT_WAIT;
      end
      S_PRT_WAIT: begin
        if (mem_rsp_valid) begin
          ctx_en  = 1'b1;
          base_d  = ent_base;
          nls_d   = ent_nls;
          rem_d   = ent_rts;
          state_d = S_DIR_REQ;
        end
      end
      S_DIR_REQ: begin
        if (dir_stop) begin
          res_en  = 1'b1;
          fault_d = FLT_BADCFG;
          state_d = S_DONE;
        end else if (mem_req_ready) begin
          ctx_en  = 1'b1;
          res_en  = 1'b1;
          la_d    = dir_addr;
          lvl_d   = lvl_q + LVL_W'(1);
          state_d = S_DIR_WAIT;
        end
      end
      S_DIR_WAIT: begin
        if (mem_rsp_valid) begin
          res_en = 1'b1;
          ctx_en = 1'b1;
          if (!ent_valid) begin
            fault_d = FLT_NOENT;
            state_d = S_DONE;
          end else if (ent_leaf) begin
            rem_d   = rem_after;
            ps_d    = rem_after;
            ra_d    = merge_ra;
            leaf_d  = mem_rsp_data;
            state_d = S_DONE;
          end else begin
            rem_d   = rem_after;
            base_d  = ent_base;
            nls_d   = ent_nls;
            state_d = S_DIR_REQ;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Walk context registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q       <= '0;
      base_q     <= '0;
      nls_q      <= '0;
      rem_q      <= '0;
      lvl_q      <= '0;
      prt_addr_q <= '0;
    end else if (ctx_en) begin
      ea_q       <= ea_d;
      base_q     <= base_d;
      nls_q      <= nls_d;
      rem_q      <= rem_d;
      lvl_q      <= lvl_d;
      prt_addr_q <= prt_addr_d;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      ra_q    <= '0;
      leaf_q  <= '0;
      la_q    <= '0;
      ps_q    <= '0;
    end else if (res_en) begin
      fault_q <= fault_d;
      ra_q    <= ra_d;
      leaf_q  <= leaf_d;
      la_q    <= la_d;
      ps_q    <= ps_d;
    end
  end

  always_comb begin
    busy          = (state_q != S_IDLE);
    done          = (state_q == S_DONE);
    fault         = fault_q;
    real_addr     = ra_q;
    leaf_entry    = leaf_q;
    leaf_addr     = la_q;
    page_shift    = ps_q;
    mem_req_valid = (state_q == S_PRT_REQ) || ((state_q == S_DIR_REQ) && !dir_stop);
    mem_req_addr  = (state_q == S_PRT_REQ) ? prt_addr_q : dir_addr;
  end
endmodule

// File: rtl/rw_walk_checker.sv
module rw_walk_checker #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [1:0]      fault,
  input logic [1:0]      leaf_flags,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_no_req_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

  p_fault_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault != 2'b11);

  p_leaf_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault == 2'b00) |-> leaf_flags == 2'b11);
endmodule

bind rw_walker rw_walk_checker #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .leaf_flags(leaf_entry[63:62]),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/sim_rw_walker.sv
module sim_rw_walker;
  localparam int EA_W  = 64;
  localparam int PA_W  = 56;
  localparam int PID_W = 16;
  localparam logic [PA_W-1:0] PRTB = 56'h100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start;
  logic [EA_W-1:0]  ea;
  logic [PID_W-1:0] pid;
  logic [PA_W-1:0]  prt_base;
  logic [4:0]       prt_size;
  logic             busy, done;
  logic [1:0]       fault;
  logic [PA_W-1:0]  real_addr, leaf_addr, mem_req_addr;
  logic [63:0]      leaf_entry, mem_rsp_data;
  logic [5:0]       page_shift;
  logic             mem_req_valid, mem_req_ready, mem_rsp_valid;

  rw_walker #(.EA_W(EA_W), .PA_W(PA_W), .PID_W(PID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .pid(pid),
    .prt_base(prt_base), .prt_size(prt_size), .busy(busy), .done(done),
    .fault(fault), .real_addr(real_addr), .leaf_entry(leaf_entry),
    .leaf_addr(leaf_addr), .page_shift(page_shift),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [63:0] mem [logic [PA_W-1:0]];
  int  reads;
  int  checks;
  int  failures;
  bit  stall_en;
  bit  finished;

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [63:0] mk_dir(input logic [PA_W-1:0] b, input logic [4:0] w);
    return {2'b10, 6'b0, b[55:8], 3'b0, w};
  endfunction

  function automatic logic [63:0] mk_leaf(input logic [PA_W-1:0] r);
    return {2'b11, 6'b0, r[55:12], 12'h0a5};
  endfunction

  function automatic logic [63:0] mk_prt(input logic [PA_W-1:0] b, input logic [4:0] w,
                                         input logic [5:0] rts);
    return {2'b00, rts, b[55:8], 3'b0, w};
  endfunction

  // Reference walk computed from the requirements
  function automatic void ref_walk(input logic [63:0] e_a, input logic [PID_W-1:0] p,
                                   input logic [PA_W-1:0] pb, input logic [4:0] psz,
                                   output logic [1:0] f, output logic [PA_W-1:0] ra,
                                   output logic [63:0] le, output logic [PA_W-1:0] la,
                                   output logic [5:0] ps, output int nrd);
    logic [63:0]     e;
    logic [PA_W-1:0] base, a, m;
    logic [63:0]     idx;
    int              w, rem;
    f = 2'b00; ra = '0; le = '0; la = '0; ps = '0; nrd = 0;
    if ((64'(p) * 64'd16) >= (64'd1 << (int'(psz) + 12))) begin
      f = 2'b01;
      return;
    end
    e = rd(pb + PA_W'(p) * 56'd16);
    nrd = 1;
    base = {e[55:8], 8'b0};
    w = int'(e[4:0]);
    rem = int'(e[61:56]);
    for (int lv = 0; lv < 5; lv++) begin
      if (lv == 4 || w < 5 || w > rem) begin
        f = 2'b10;
        return;
      end
      idx = (e_a >> (rem - w)) & ((64'd1 << w) - 64'd1);
      a = base + PA_W'(idx * 64'd8);
      e = rd(a);
      nrd++;
      if (!e[63]) begin
        f = 2'b01;
        return;
      end
      rem = rem - w;
      if (e[62]) begin
        m  = (PA_W'(1) << rem) - PA_W'(1);
        ra = ({e[55:12], 12'b0} & ~m) | (e_a[55:0] & m);
        le = e;
        la = a;
        ps = 6'(rem);
        return;
      end
      base = {e[55:8], 8'b0};
      w = int'(e[4:0]);
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory responder: one-cycle latency, optional random stalls on ready
  initial begin : responder
    logic            pend;
    logic [PA_W-1:0] paddr;
    logic [7:0]      lfsr;
    pend = 1'b0;
    paddr = '0;
    lfsr = 8'h5a;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = rd(paddr);
        pend = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = stall_en ? lfsr[0] : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        paddr = mem_req_addr;
        reads++;
      end
    end
  end

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!done && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (!done) chk(1'b0, req, "watchdog waiting for done", 64'(t), 64'd0);
  endtask

  task automatic walk(input logic [63:0] e_a, input logic [PID_W-1:0] p,
                      input logic [4:0] psz, input string req);
    logic [1:0]      ef;
    logic [PA_W-1:0] era, ela;
    logic [63:0]     ele;
    logic [5:0]      eps;
    int              enrd;
    ref_walk(e_a, p, PRTB, psz, ef, era, ele, ela, eps, enrd);
    @(negedge clk);
    reads = 0;
    start = 1'b1; ea = e_a; pid = p; prt_base = PRTB; prt_size = psz;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
    chk(fault == ef, req, "fault", 64'(fault), 64'(ef));
    chk(reads == enrd, req, "read count", 64'(reads), 64'(enrd));
    if (ef == 2'b00) begin
      chk(real_addr == era, req, "real_addr", 64'(real_addr), 64'(era));
      chk(page_shift == eps, req, "page_shift", 64'(page_shift), 64'(eps));
      chk(leaf_entry == ele, req, "leaf_entry", leaf_entry, ele);
      chk(leaf_addr == ela, req, "leaf_addr", 64'(leaf_addr), 64'(ela));
    end
  endtask

  // Table construction
  task automatic build_tables();
    logic [PA_W-1:0] l2, l3;
    int              w2;
    // pid 0 and 255: sweep tree, 30 translated bits, root width 5
    mem[PRTB + 56'd0]    = mk_prt(56'h10000, 5'd5, 6'd30);
    mem[PRTB + 56'd4080] = mk_prt(56'h10000, 5'd5, 6'd30);
    // pid 1: root width 4 (too narrow)
    mem[PRTB + 56'd16] = mk_prt(56'h10000, 5'd4, 6'd30);
    // pid 2: root width 9 with only 8 bits remaining
    mem[PRTB + 56'd32] = mk_prt(56'h10000, 5'd9, 6'd8);
    // pid 3: deep chain of 5-bit levels, 40 translated bits
    mem[PRTB + 56'd48] = mk_prt(56'h20000, 5'd5, 6'd40);
    mem[56'h20000] = mk_dir(56'h21000, 5'd5);
    mem[56'h21000] = mk_dir(56'h22000, 5'd5);
    mem[56'h22000] = mk_dir(56'h23000, 5'd5);
    mem[56'h23000] = mk_dir(56'h24000, 5'd5);
    mem[56'h23008] = mk_leaf(56'hABCDE_F00000);
    mem[56'h24000] = mk_leaf(56'h1234_5000);
    for (int i = 0; i < 32; i++) begin
      if (i % 4 == 0) begin
        mem[56'h10000 + 56'(i) * 8] = mk_leaf(56'(i) * 56'h3_0004_0000 + 56'hABC000);
      end else if (i % 4 >= 2) begin
        w2 = (i % 4 == 2) ? 5 : 6;
        l2 = 56'h30000 + 56'(i) * 56'h1000;
        mem[56'h10000 + 56'(i) * 8] = mk_dir(l2, 5'(w2));
        for (int j = 0; j < (1 << w2); j++) begin
          if (j % 3 == 1) begin
            mem[l2 + 56'(j) * 8] = mk_leaf(56'(i * 64 + j) * 56'h7_1000);
          end else if (j % 3 == 2) begin
            l3 = 56'h80000 + 56'(i * 64 + j) * 56'h200;
            if (j < 8) begin
              mem[l2 + 56'(j) * 8] = mk_dir(l3, 5'd5);
              for (int k = 0; k < 32; k++) begin
                if (k != 7) mem[l3 + 56'(k) * 8] = mk_leaf(56'(k + 1) * 56'h9_0000_0000 + 56'(j) * 56'h1000);
              end
            end else begin
              mem[l2 + 56'(j) * 8] = mk_dir(l3, 5'd3);
            end
          end
        end
      end
    end
  endtask

  // Global watchdog
  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] ref_ra;
    logic [1:0]  d1;
    logic [PA_W-1:0] d2, d4;
    logic [63:0] d3;
    logic [5:0]  d5;
    int          d6;
    checks = 0; failures = 0; reads = 0; stall_en = 1'b0; finished = 1'b0;
    start = 1'b0; ea = '0; pid = '0; prt_base = PRTB; prt_size = '0;
    build_tables();
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!busy && !done && !mem_req_valid, "R1", "in reset busy/done/req",
        {61'b0, busy, done, mem_req_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R1", "after reset busy/done/req",
        {61'b0, busy, done, mem_req_valid}, 64'd0);

    // R7: leaf at root level (huge page) and one level deeper
    walk(64'h0000_0000_0000_1234, 16'd0, 5'd0, "R7");
    walk({34'h0, 5'd6, 25'h0123456}, 16'd0, 5'd0, "R8");
    // R3: same tree through the last slot of a minimum-size table
    walk(64'h0000_0000_2ABC_DEF1, 16'd255, 5'd0, "R3");
    // R2: pid at the table boundary, then inside a larger table
    walk(64'h0, 16'd256, 5'd0, "R2");
    walk(64'h0, 16'd256, 5'd1, "R2");
    walk(64'h0, 16'hFFFF, 5'd11, "R2");
    // R5: width too small, width larger than remaining size
    walk(64'h0, 16'd1, 5'd0, "R5");
    walk(64'hFF, 16'd2, 5'd0, "R5");
    // R6: hole at root level
    walk({34'h0, 5'd1, 25'h0}, 16'd0, 5'd0, "R6");
    // R9: four-level leaf succeeds, fifth level refused
    walk(64'h0000_0000_0010_0000, 16'd3, 5'd0, "R9");
    walk(64'h0, 16'd3, 5'd0, "R9");

    // R4: sweep of hashed addresses across the mixed tree, with stalls
    for (int n = 0; n < 400; n++) begin
      stall_en = (n % 2 == 1);
      walk(64'(n) * 64'h9E37_79B9_7F4A_7C15, 16'd0, 5'd0, "R4");
    end
    stall_en = 1'b0;

    // R10: start held while busy is ignored
    ref_walk(64'h0000_0000_0000_0777, 16'd0, PRTB, 5'd0, d1, d2, d3, d4, d5, d6);
    ref_ra = 64'(d2);
    @(negedge clk);
    start = 1'b1; ea = 64'h777; pid = 16'd0; prt_size = 5'd0;
    @(negedge clk);
    ea = 64'h3FFF_FFFF; pid = 16'd300;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    chk(fault == 2'b00, "R10", "fault after ignored start", 64'(fault), 64'd0);
    chk(real_addr == d2, "R10", "real_addr after ignored start", 64'(real_addr), ref_ra);
    @(negedge clk);
    chk(!done && !busy, "R10", "done one cycle then idle", {62'b0, done, busy}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid, "R10", "no extra walk", {62'b0, busy, mem_req_valid}, 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule